// File: doc/BRIEF.md
# Read-Enable Latency Trainer with Byte-Lane Deskew

A DRAM read path gives no strobe that says when returned data is good. This block works that timing out at run time. Once memory initialization has finished, it asks the command path to write a fixed four-beat training burst and then to read it back. It then watches the captured data of each byte lane on its own, looking for the training burst. From the cycle in which each lane shows it, the block learns that lane's command-to-data latency.

The lanes can settle on different latencies. The block adds extra register stages to the early lanes, so every byte of a read word leaves on the same cycle. After that, each read command from the controller yields a two-cycle burst of aligned data, marked by a valid strobe. A ready flag announces a successful calibration. An error flag reports that some lane never showed the burst inside the search window.

Capture data enters as two beats per clock. The low half of the bus is the rising-edge beat and the high half is the falling-edge beat. Byte lane l sits at bits [8l+7:8l] of each half. Output data uses the same layout.

Top module: `rden_cal_top`

## Requirements
- R1: After reset, ready_o, error_o, rd_valid_o, trn_wr_o and trn_rd_o are low. No training write starts until init_done_i has been seen high.
- R2: Training starts one cycle after init_done_i is sampled high. trn_wr_o is high for exactly two consecutive cycles. In every lane, trn_wdata_o carries rise 0xAA / fall 0x55 in the first cycle and rise 0x55 / fall 0xAA in the second.
- R3: trn_rd_o is a single-cycle pulse. It comes GAP_CYC+1 cycles after the second write cycle, and never together with trn_wr_o.
- R4: A lane's latency L is the cycle count from the trn_rd_o cycle to the first cycle in which that lane's captured bytes are rise 0xAA / fall 0x55, provided the next cycle shows rise 0x55 / fall 0xAA. L is searched from 0 to MAX_LAT.
- R5: Exactly MAX_LAT+3 cycles after the trn_rd_o cycle, one of two flags rises. ready_o rises if every lane found a latency. Otherwise error_o rises; this covers a lane that stays silent, a lane that repeats the first word, and a lane whose latency is MAX_LAT+1. Both flags are exclusive and hold until reset.
- R6: After ready_o, a usr_rd_i pulse in cycle T gives rd_valid_o high in cycles T+M+2 and T+M+3 and low in the cycles around them, where M is the largest lane latency.
- R7: usr_rd_i has no effect while ready_o is low. rd_valid_o stays low before calibration and after a failed calibration.
- R8: In the valid cycles, every lane of rd_data_o holds the word that lane captured in cycles T+L and T+L+1, so all lanes line up. Reads two cycles apart give four consecutive valid cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_done_i | input | 1 | Memory initialization finished |
| usr_rd_i | input | 1 | Read command issued by the controller (one cycle per burst) |
| cap_data_i | input | 2*LANES*8 | Captured read data, rise beat low half, fall beat high half |
| trn_wr_o | output | 1 | Training write request, high for both data cycles |
| trn_rd_o | output | 1 | Training read request pulse |
| trn_wdata_o | output | 2*LANES*8 | Training write data |
| rd_data_o | output | 2*LANES*8 | Lane-aligned read data |
| rd_valid_o | output | 1 | rd_data_o is valid this cycle |
| ready_o | output | 1 | Calibration succeeded |
| error_o | output | 1 | Calibration failed |

## Verification
Each result has a fixed due cycle:
- trn_wr_o: due the cycle after init_done_i is sampled.
- trn_rd_o: due GAP_CYC+1 cycles after the second write cycle.
- ready_o or error_o: due MAX_LAT+3 cycles after the training read.
- rd_valid_o and aligned data: due M+2 and M+3 cycles after a user read.

The bench counts cycles from the cycle of each stimulus and samples outputs at the falling edge. It asserts both the due cycle and the quiet cycles on either side. Its memory model answers each read with lane-specific latencies, so a lane that arrives early or late, or a deskew tap that is off by one, shows up as wrong data in a valid cycle.

// File: rtl/rden_pkg.sv
package rden_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  localparam logic [BYTE_W-1:0] PAT_A = 8'hAA;
  localparam logic [BYTE_W-1:0] PAT_B = 8'h55;

  // Per-lane word is {fall byte, rise byte}
  localparam logic [WORD_W-1:0] TRN_WORD0 = {PAT_B, PAT_A};
  localparam logic [WORD_W-1:0] TRN_WORD1 = {PAT_A, PAT_B};

  typedef enum logic [3:0] {
    S_WAIT, S_WR0, S_WR1, S_GAP, S_RD, S_SRCH, S_EVAL, S_DONE, S_FAIL
  } seq_state_t;
endpackage

// File: rtl/rden_seq.sv
module rden_seq
  import rden_pkg::*;
#(
  parameter int MAX_LAT = 15,
  parameter int GAP_CYC = 4,
  localparam int CNT_W = $clog2(MAX_LAT + 2),
  localparam int GAP_W = $clog2(GAP_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_done_i,
  input  logic             all_found_i,
  output logic             trn_wr_o,
  output logic             trn_rd_o,
  output logic             wr_second_o,
  output logic             srch_clr_o,
  output logic             srch_act_o,
  output logic             eval_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ready_o,
  output logic             error_o
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MAX_LAT + 1);
  localparam logic [GAP_W-1:0] LAST_GAP = GAP_W'(GAP_CYC - 1);

  seq_state_t       st, nxt;
  logic [GAP_W-1:0] gap_q;

  always_comb begin
    nxt = st;
    case (st)
      S_WAIT: if (init_done_i) nxt = S_WR0;
      S_WR0:  nxt = S_WR1;
      S_WR1:  nxt = S_GAP;
      S_GAP:  if (gap_q == LAST_GAP) nxt = S_RD;
      S_RD:   nxt = S_SRCH;
      S_SRCH: if (cnt_o == LAST_CNT) nxt = S_EVAL;
      S_EVAL: nxt = all_found_i ? S_DONE : S_FAIL;
      S_DONE: nxt = S_DONE;
      S_FAIL: nxt = S_FAIL;
      default: nxt = S_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_WAIT;
      gap_q       <= '0;
      cnt_o       <= '0;
      trn_wr_o    <= 1'b0;
      trn_rd_o    <= 1'b0;
      wr_second_o <= 1'b0;
      ready_o     <= 1'b0;
      error_o     <= 1'b0;
    end else begin
      st          <= nxt;
      gap_q       <= (st == S_GAP) ? gap_q + 1'b1 : '0;
      if (nxt == S_RD)
        cnt_o <= '0;
      else if (st == S_RD || st == S_SRCH)
        cnt_o <= cnt_o + 1'b1;
      trn_wr_o    <= (nxt == S_WR0) || (nxt == S_WR1);
      wr_second_o <= (nxt == S_WR1);
      trn_rd_o    <= (nxt == S_RD);
      ready_o     <= (nxt == S_DONE);
      error_o     <= (nxt == S_FAIL);
    end
  end

  assign srch_clr_o = (st == S_WR0);
  assign srch_act_o = (st == S_RD) || (st == S_SRCH);
  assign eval_o     = (st == S_EVAL);
endmodule

// File: rtl/rden_lane_search.sv
module rden_lane_search
  import rden_pkg::*;
#(
  parameter int MAX_LAT = 15,
  localparam int LAT_W = $clog2(MAX_LAT + 1),
  localparam int CNT_W = $clog2(MAX_LAT + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              act_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              found_o,
  output logic [LAT_W-1:0]  lat_o
);
  logic prev_hit;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      found_o  <= 1'b0;
      prev_hit <= 1'b0;
      lat_o    <= '0;
    end else if (act_i) begin
      prev_hit <= (word_i == TRN_WORD0);
      // first word seen last cycle, second word now: latency is last cycle
      if (!found_o && prev_hit && word_i == TRN_WORD1) begin
        found_o <= 1'b1;
        lat_o   <= LAT_W'(cnt_i - 1'b1);
      end
    end
  end
endmodule

// File: rtl/rden_lane_deskew.sv
module rden_lane_deskew
  import rden_pkg::*;
#(
  parameter int MAX_LAT = 15,
  localparam int LAT_W = $clog2(MAX_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_i,
  input  logic [LAT_W-1:0]  tap_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] stg [0:MAX_LAT];

  always_ff @(posedge clk) begin
    stg[0] <= word_i;
    for (int k = 1; k <= MAX_LAT; k++) stg[k] <= stg[k-1];
  end

  always_ff @(posedge clk) begin
    if (rst) word_o <= '0;
    else     word_o <= stg[tap_i];
  end
endmodule

// File: rtl/rden_valid_pipe.sv
module rden_valid_pipe #(
  parameter int MAX_LAT = 15,
  localparam int LAT_W = $clog2(MAX_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_i,
  input  logic [LAT_W-1:0] tap_i,
  output logic             valid_o
);
  logic [MAX_LAT+1:0] vsh;
  logic [LAT_W:0]     tap_a, tap_b;

  assign tap_a = {1'b0, tap_i};
  assign tap_b = tap_a + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      vsh     <= '0;
      valid_o <= 1'b0;
    end else begin
      vsh     <= {vsh[MAX_LAT:0], cmd_i};
      // two data cycles per burst
      valid_o <= vsh[tap_a] | vsh[tap_b];
    end
  end
endmodule

// File: rtl/rden_cal_top.sv
module rden_cal_top
  import rden_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int MAX_LAT = 15,
  parameter int GAP_CYC = 4,
  localparam int DW = LANES * BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_done_i,
  input  logic          usr_rd_i,
  input  logic [2*DW-1:0] cap_data_i,
  output logic          trn_wr_o,
  output logic          trn_rd_o,
  output logic [2*DW-1:0] trn_wdata_o,
  output logic [2*DW-1:0] rd_data_o,
  output logic          rd_valid_o,
  output logic          ready_o,
  output logic          error_o
);
  localparam int LAT_W = $clog2(MAX_LAT + 1);
  localparam int CNT_W = $clog2(MAX_LAT + 2);

  logic             wr_second, srch_clr, srch_act, eval_now, all_found;
  logic [CNT_W-1:0] srch_cnt;
  logic [LANES-1:0] lane_found;
  logic [LAT_W-1:0] lane_lat [LANES];
  logic [LAT_W-1:0] lane_tap [LANES];
  logic [LAT_W-1:0] max_lat_q, max_lat_d;

  assign all_found = &lane_found;

  rden_seq #(.MAX_LAT(MAX_LAT), .GAP_CYC(GAP_CYC)) u_seq (
    .clk(clk), .rst(rst), .init_done_i(init_done_i), .all_found_i(all_found),
    .trn_wr_o(trn_wr_o), .trn_rd_o(trn_rd_o), .wr_second_o(wr_second),
    .srch_clr_o(srch_clr), .srch_act_o(srch_act), .eval_o(eval_now),
    .cnt_o(srch_cnt), .ready_o(ready_o), .error_o(error_o)
  );

  always_comb begin
    max_lat_d = '0;
    for (int l = 0; l < LANES; l++)
      if (lane_lat[l] > max_lat_d) max_lat_d = lane_lat[l];
  end

  always_ff @(posedge clk) begin
    if (rst)           max_lat_q <= '0;
    else if (eval_now) max_lat_q <= max_lat_d;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WORD_W-1:0] cap_word, out_word;

    assign cap_word = {cap_data_i[DW + g*BYTE_W +: BYTE_W], cap_data_i[g*BYTE_W +: BYTE_W]};

    rden_lane_search #(.MAX_LAT(MAX_LAT)) u_search (
      .clk(clk), .rst(rst), .clr_i(srch_clr), .act_i(srch_act),
      .cnt_i(srch_cnt), .word_i(cap_word),
      .found_o(lane_found[g]), .lat_o(lane_lat[g])
    );

    assign lane_tap[g] = max_lat_q - lane_lat[g];

    rden_lane_deskew #(.MAX_LAT(MAX_LAT)) u_deskew (
      .clk(clk), .rst(rst), .word_i(cap_word), .tap_i(lane_tap[g]), .word_o(out_word)
    );

    assign rd_data_o[g*BYTE_W +: BYTE_W]      = out_word[BYTE_W-1:0];
    assign rd_data_o[DW + g*BYTE_W +: BYTE_W] = out_word[WORD_W-1:BYTE_W];
    assign trn_wdata_o[g*BYTE_W +: BYTE_W]      = wr_second ? TRN_WORD1[BYTE_W-1:0] : TRN_WORD0[BYTE_W-1:0];
    assign trn_wdata_o[DW + g*BYTE_W +: BYTE_W] = wr_second ? TRN_WORD1[WORD_W-1:BYTE_W] : TRN_WORD0[WORD_W-1:BYTE_W];
  end

  rden_valid_pipe #(.MAX_LAT(MAX_LAT)) u_valid (
    .clk(clk), .rst(rst), .cmd_i(usr_rd_i & ready_o), .tap_i(max_lat_q), .valid_o(rd_valid_o)
  );
endmodule

// File: rtl/rden_cal_chk.sv
module rden_cal_chk (
  input logic clk,
  input logic rst,
  input logic init_done_i,
  input logic trn_wr_o,
  input logic trn_rd_o,
  input logic rd_valid_o,
  input logic ready_o,
  input logic error_o
);
  logic seen_init;

  always_ff @(posedge clk) begin
    if (rst)              seen_init <= 1'b0;
    else if (init_done_i) seen_init <= 1'b1;
  end

  assert_wait_init_R1: assert property (@(posedge clk) disable iff (rst)
    trn_wr_o |-> seen_init);

  assert_wr_two_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(trn_wr_o) |=> trn_wr_o);

  assert_wr_end_R2: assert property (@(posedge clk) disable iff (rst)
    (trn_wr_o && $past(trn_wr_o)) |=> !trn_wr_o);

  assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    trn_rd_o |=> !trn_rd_o);

  assert_rd_apart_R3: assert property (@(posedge clk) disable iff (rst)
    trn_rd_o |-> !trn_wr_o);

  assert_flags_excl_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ready_o, error_o}));

  assert_ready_hold_R5: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> ready_o);

  assert_error_hold_R5: assert property (@(posedge clk) disable iff (rst)
    error_o |=> error_o);

  assert_valid_burst_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid_o) |=> rd_valid_o);

  assert_no_valid_R7: assert property (@(posedge clk) disable iff (rst)
    !ready_o |-> !rd_valid_o);
endmodule

bind rden_cal_top rden_cal_chk u_chk (
  .clk(clk), .rst(rst), .init_done_i(init_done_i), .trn_wr_o(trn_wr_o),
  .trn_rd_o(trn_rd_o), .rd_valid_o(rd_valid_o), .ready_o(ready_o), .error_o(error_o)
);

// File: tb/sim_rden_cal_top.sv
`timescale 1ns/1ps
module sim_rden_cal_top;
  localparam int LANES   = 4;
  localparam int MAX_LAT = 15;
  localparam int GAP_CYC = 4;
  localparam int DW      = LANES * 8;
  localparam int NV      = 7;

  // lane code: 0..29 latency, 30 repeats first word, 31 silent
  localparam int VEC_LAT [NV][LANES] = '{
    '{3, 3, 3, 3}, '{2, 5, 4, 7}, '{0, 0, 0, 0}, '{15, 15, 0, 15},
    '{4, 4, 16, 4}, '{1, 2, 3, 31}, '{6, 30, 6, 6}
  };
  localparam bit VEC_OK [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};

  logic clk = 1'b0, rst = 1'b1, init_done_i = 1'b0, usr_rd_i = 1'b0;
  logic [2*DW-1:0] cap_data_i = '0;
  logic trn_wr_o, trn_rd_o, rd_valid_o, ready_o, error_o;
  logic [2*DW-1:0] trn_wdata_o, rd_data_o;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  int lat_cfg [LANES];
  logic [7:0] idh [0:31];
  logic [7:0] cur_id = 8'd0;

  always #2.5 clk = ~clk;

  rden_cal_top #(.LANES(LANES), .MAX_LAT(MAX_LAT), .GAP_CYC(GAP_CYC)) u0 (
    .clk(clk), .rst(rst), .init_done_i(init_done_i), .usr_rd_i(usr_rd_i),
    .cap_data_i(cap_data_i), .trn_wr_o(trn_wr_o), .trn_rd_o(trn_rd_o),
    .trn_wdata_o(trn_wdata_o), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .ready_o(ready_o), .error_o(error_o)
  );

  function automatic logic [15:0] word_of(logic [7:0] id, int j, int l);
    logic [7:0] r, f;
    if (id == 8'd1) return (j == 0) ? 16'h55AA : 16'hAA55;
    r = id ^ ((j == 0) ? 8'h00 : 8'h80);
    f = 8'(16 * l + j);
    return {f, r};
  endfunction

  function automatic logic [15:0] model_word(int l);
    int c = lat_cfg[l];
    if (c == 31) return 16'h0000;
    if (c == 30) return 16'h55AA;
    if (idh[c] != 8'd0)   return word_of(idh[c], 0, l);
    if (idh[c+1] != 8'd0) return word_of(idh[c+1], 1, l);
    return 16'h0000;
  endfunction

  function automatic logic [2*DW-1:0] pack_pat(int j);
    logic [2*DW-1:0] v;
    for (int l = 0; l < LANES; l++) begin
      v[l*8 +: 8]      = (j == 0) ? 8'hAA : 8'h55;
      v[DW + l*8 +: 8] = (j == 0) ? 8'h55 : 8'hAA;
    end
    return v;
  endfunction

  function automatic logic [2*DW-1:0] pack_read(logic [7:0] id, int j);
    logic [2*DW-1:0] v;
    logic [15:0] w;
    for (int l = 0; l < LANES; l++) begin
      w = word_of(id, j, l);
      v[l*8 +: 8]      = w[7:0];
      v[DW + l*8 +: 8] = w[15:8];
    end
    return v;
  endfunction

  // memory model: answers each read per lane after that lane's latency
  always @(negedge clk) begin
    logic [15:0] w;
    #1;
    for (int k = 31; k > 0; k--) idh[k] = idh[k-1];
    idh[0] = rst ? 8'd0 : (trn_rd_o ? 8'd1 : (usr_rd_i ? cur_id : 8'd0));
    for (int l = 0; l < LANES; l++) begin
      w = model_word(l);
      cap_data_i[l*8 +: 8]      = w[7:0];
      cap_data_i[DW + l*8 +: 8] = w[15:8];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; init_done_i = 1'b0; usr_rd_i = 1'b0;
    for (int k = 0; k < 32; k++) idh[k] = 8'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // one read in cycle T; valid due at T+m+2, T+m+3
  task automatic read_check(input int m, input logic [7:0] id, input bit expect_valid);
    bit ev;
    usr_rd_i = 1'b1; cur_id = id;
    for (int k = 1; k <= m + 5; k++) begin
      @(negedge clk);
      if (k == 1) usr_rd_i = 1'b0;
      ev = expect_valid && (k == m + 2 || k == m + 3);
      if (expect_valid) chk(rd_valid_o == ev, "R6 valid timing", 64'(rd_valid_o), 64'(ev));
      else              chk(!rd_valid_o, "R7 read ignored", 64'(rd_valid_o), 64'd0);
      if (ev) chk(rd_data_o == pack_read(id, k - m - 2), "R4 R8 aligned data",
                  64'(rd_data_o), 64'(pack_read(id, k - m - 2)));
    end
  endtask

  // reads at T and T+2; four consecutive valid cycles
  task automatic b2b_check(input int m);
    bit ev;
    logic [2*DW-1:0] exp;
    usr_rd_i = 1'b1; cur_id = 8'd20;
    for (int k = 1; k <= m + 7; k++) begin
      @(negedge clk);
      if (k == 1) usr_rd_i = 1'b0;
      if (k == 2) begin usr_rd_i = 1'b1; cur_id = 8'd21; end
      if (k == 3) usr_rd_i = 1'b0;
      ev = (k >= m + 2) && (k <= m + 5);
      chk(rd_valid_o == ev, "R8 back-to-back valid", 64'(rd_valid_o), 64'(ev));
      if (ev) begin
        exp = (k <= m + 3) ? pack_read(8'd20, k - m - 2) : pack_read(8'd21, k - m - 4);
        chk(rd_data_o == exp, "R8 back-to-back data", 64'(rd_data_o), 64'(exp));
      end
    end
  endtask

  task automatic run_vec(input int v);
    int n, m;
    bit ok;
    m = 0;
    for (int l = 0; l < LANES; l++) begin
      lat_cfg[l] = VEC_LAT[v][l];
      if (lat_cfg[l] < 30 && lat_cfg[l] > m) m = lat_cfg[l];
    end
    ok = VEC_OK[v];
    do_reset();
    init_done_i = 1'b1;
    @(negedge clk);
    chk(trn_wr_o && trn_wdata_o == pack_pat(0), "R2 first write cycle", 64'(trn_wdata_o), 64'(pack_pat(0)));
    @(negedge clk);
    chk(trn_wr_o && trn_wdata_o == pack_pat(1), "R2 second write cycle", 64'(trn_wdata_o), 64'(pack_pat(1)));
    n = 0;
    do begin @(negedge clk); n++; end while (!trn_rd_o && n < 40);
    chk(n == GAP_CYC + 1, "R3 read request delay", 64'(n), 64'(GAP_CYC + 1));
    @(negedge clk);
    n = 1;
    chk(!trn_rd_o, "R3 single read pulse", 64'(trn_rd_o), 64'd0);
    while (!(ready_o || error_o) && n < 60) begin @(negedge clk); n++; end
    chk(n == MAX_LAT + 3, "R5 flag timing", 64'(n), 64'(MAX_LAT + 3));
    chk(ready_o == ok && error_o == !ok, "R5 outcome", 64'({ready_o, error_o}), 64'({ok, !ok}));
    @(negedge clk);
    if (ok) begin
      read_check(m, 8'(2 + v), 1'b1);
      if (v == 1) b2b_check(m);
    end else begin
      read_check(m, 8'(2 + v), 1'b0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < LANES; l++) lat_cfg[l] = 3;
    for (int k = 0; k < 32; k++) idh[k] = 8'd0;
    // R1: reset state and no training before init_done_i
    do_reset();
    chk({ready_o, error_o, rd_valid_o, trn_wr_o, trn_rd_o} == 5'b0, "R1 reset state",
        64'({ready_o, error_o, rd_valid_o, trn_wr_o, trn_rd_o}), 64'd0);
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      chk(!trn_wr_o && !trn_rd_o && !ready_o, "R1 waits for init",
          64'({trn_wr_o, trn_rd_o, ready_o}), 64'd0);
    end
    // R7: read before calibration is ignored
    read_check(3, 8'd40, 1'b0);
    // vector table
    for (int v = 0; v < NV; v++) run_vec(v);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule